// File: doc/BRIEF.md
# Fixed-Point Cross-Entropy Error Unit

This block produces the backward error of a ten-way classifier, one sample at a time, during on-chip fine-tuning. A start pulse hands it the ten logits of the sample and the index of the correct class. The block then works out a softmax probability for each class. It reads the exponentials from a register table that has one entry for every possible logit code. It adds those values into a wide sum, and a restoring divider turns each class's share into an 8-bit quotient. The block subtracts the one-hot target, multiplies the result by 1.375 using only shifts and adds, and saturates it into a signed byte. The errors then leave one per cycle on a serial port, each with a valid flag and the class index.

The table holds a base-2 exponential with a linear mantissa. For each power-of-two step of the logit the value doubles, and inside a step it rises linearly with the four fraction bits. This keeps every entry an exact integer. The bench can reproduce any entry from a two-line formula.

The scale by 1.375 lifts small errors clear of the 1/128 step of the output format, so that they do not round to zero. Saturation keeps the large errors from wrapping.

Top module: `ce_error_unit`

## Requirements
- R1: While reset is held and directly after it, `err_valid_o` is 0 and `err_o` is 0.
- R2: Each logit is an 8-bit two's complement value with 4 fraction bits. Logit of class c sits at bits `[8c+7:8c]` of `logits_i`. Its table value is `(16 + f) << (i + 8)`, where i is the signed integer part (the logit shifted right arithmetically by 4) and f is the low 4 bits.
- R3: The sum S covers the table values of all ten classes. The probability code of class c is `floor(E_c * 128 / S)`, an unsigned 8-bit quotient in the range 0 to 128.
- R4: The raw error of class c is its probability code minus 128 when c equals the label, and the probability code unchanged otherwise. So the target error is never positive and every other error is never negative.
- R5: The raw error d is scaled to `d + (d >>> 2) + (d >>> 3)` with arithmetic (flooring) shifts.
- R6: The scaled error is saturated to the range -128 to 127. It is output as two's complement with 1 sign bit and 7 fraction bits.
- R7: Count the clock edge that samples `start_i` as edge 0. The error of class 0 is then registered at edge 11, and classes 1 to 9 follow on edges 12 to 20 in ascending order, with `err_cls_o` giving the class. `err_valid_o` is 0 again after edge 21.
- R8: A start whose label is 10 or more is rejected: no error is produced for it, and the block stays ready for the next start.
- R9: A start that arrives while a sample is in progress is ignored; the running sample's results are unchanged and no extra results follow.
- R10: Each sample's errors depend only on its own logits and label. Back-to-back samples do not influence each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a sample; sampled only when idle |
| label_i | input | 4 | Index of the correct class |
| logits_i | input | 80 | Ten signed Q3.4 logits, class c at bits 8c+7:8c |
| err_valid_o | output | 1 | An error is present on `err_o` |
| err_cls_o | output | 4 | Class of the error on `err_o` |
| err_o | output | 8 | Scaled error, sign plus 7 fraction bits |

## Verification
A valid error is due 11 cycles after the edge that takes the start, and the remaining nine errors follow on the next nine edges. The bench counts rising edges from that start edge and expects the first valid sample on the twelfth edge it counts. It then compares one class per cycle, with every read taken on the falling edge, and confirms that the flag is low one edge after class 9. For rejected labels, and after a start that arrives while a sample is running, the bench watches the valid flag over a window longer than a whole sample.

// File: rtl/ce_error_unit.sv
module ce_error_unit #(
  parameter int NCLS = 10,
  parameter int LW   = 8,
  parameter int FB   = 4,
  parameter int QW   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [$clog2(NCLS)-1:0]      label_i,
  input  logic [NCLS*LW-1:0]           logits_i,
  output logic                         err_valid_o,
  output logic [$clog2(NCLS)-1:0]      err_cls_o,
  output logic signed [QW-1:0]         err_o
);
  localparam int CW   = $clog2(NCLS);
  localparam int NSH  = 1 << (LW - FB);
  localparam int EW   = FB + 1 + NSH;
  localparam int SW   = EW + $clog2(NCLS);
  localparam int DW   = SW + QW;
  localparam int XW   = QW + 2;
  localparam logic signed [XW-1:0] ONE  = XW'(1 << (QW - 1));
  localparam logic signed [XW-1:0] QMAX = ONE - 1;
  localparam logic signed [XW-1:0] QMIN = -ONE;
  localparam logic [1:0] S_IDLE = 2'd0, S_SUM = 2'd1, S_EMIT = 2'd2;

  logic [EW-1:0] exp_tab [1<<LW];
  for (genvar g = 0; g < (1 << LW); g++) begin : g_tab
    localparam int IPU = g >> FB;
    localparam int SH  = (IPU >= NSH/2) ? IPU - NSH/2 : IPU + NSH/2;
    localparam int FR  = g % (1 << FB);
    localparam logic [EW-1:0] V = EW'((1 << FB) + FR) << SH;
    assign exp_tab[g] = V;
  end

  logic [1:0]             st_q;
  logic [CW-1:0]          idx_q, lab_q;
  logic [NCLS*LW-1:0]     lgt_q;
  logic [SW-1:0]          acc_q;
  logic [EW-1:0]          e_cur;
  logic [QW-1:0]          quo;
  logic signed [XW-1:0]   dif, scl, tgt;
  logic [QW-1:0]          sat;
  logic                   last;

  assign e_cur = exp_tab[lgt_q[idx_q*LW +: LW]];
  assign last  = (idx_q == CW'(NCLS - 1));

  always_comb begin
    logic [DW-1:0] rem;
    rem = DW'(e_cur) << (QW - 1);
    quo = '0;
    for (int b = QW - 1; b >= 0; b--) begin
      if (rem >= (DW'(acc_q) << b)) begin
        rem    = rem - (DW'(acc_q) << b);
        quo[b] = 1'b1;
      end
    end
  end

  assign tgt = (idx_q == lab_q) ? ONE : '0;
  assign dif = $signed({2'b00, quo}) - tgt;
  assign scl = dif + (dif >>> 2) + (dif >>> 3);
  assign sat = (scl > QMAX) ? QMAX[QW-1:0] :
               (scl < QMIN) ? QMIN[QW-1:0] : scl[QW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      idx_q       <= '0;
      lab_q       <= '0;
      lgt_q       <= '0;
      acc_q       <= '0;
      err_valid_o <= 1'b0;
      err_cls_o   <= '0;
      err_o       <= '0;
    end else begin
      err_valid_o <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i && (label_i < CW'(NCLS))) begin
          lgt_q <= logits_i;
          lab_q <= label_i;
          acc_q <= '0;
          idx_q <= '0;
          st_q  <= S_SUM;
        end
        S_SUM: begin
          acc_q <= acc_q + SW'(e_cur);
          idx_q <= last ? '0 : idx_q + 1'b1;
          if (last) st_q <= S_EMIT;
        end
        S_EMIT: begin
          err_valid_o <= 1'b1;
          err_o       <= sat;
          err_cls_o   <= idx_q;
          idx_q       <= last ? '0 : idx_q + 1'b1;
          if (last) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

module ce_error_unit_chk #(
  parameter int NCLS = 10,
  parameter int QW   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic [$clog2(NCLS)-1:0] label_i,
  input logic                    valid,
  input logic [$clog2(NCLS)-1:0] cls,
  input logic [QW-1:0]           err,
  input logic [$clog2(NCLS)-1:0] lab_q,
  input logic [1:0]              st
);
  localparam int CW = $clog2(NCLS);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && $past(st) == 2'd0) |-> !valid);
  p_first_cls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> cls == '0);
  p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cls != CW'(NCLS - 1)) |=> (valid && cls == $past(cls) + 1'b1));
  p_last_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cls == CW'(NCLS - 1)) |=> !valid);
  p_target_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cls == lab_q) |-> (err[QW-1] || err == '0));
  p_other_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cls != lab_q) |-> !err[QW-1]);
  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && start_i && label_i >= CW'(NCLS)) |=> st == 2'd0);
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0 && start_i) |=> $stable(lab_q));
endmodule

bind ce_error_unit ce_error_unit_chk #(.NCLS(NCLS), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .label_i(label_i),
  .valid(err_valid_o), .cls(err_cls_o), .err(err_o),
  .lab_q(lab_q), .st(st_q)
);

// File: tb/ce_error_unit_bench.sv
module ce_error_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_i = 0;
  logic [3:0]  label_i = 0;
  logic [79:0] logits_i = '0;
  logic        err_valid_o;
  logic [3:0]  err_cls_o;
  logic [7:0]  err_o;

  int checks = 0;
  int errors = 0;

  ce_error_unit u_ce_error_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .label_i(label_i),
    .logits_i(logits_i), .err_valid_o(err_valid_o),
    .err_cls_o(err_cls_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_ref(int l);
    int ip = l >>> 4;
    int f  = l & 15;
    return longint'(16 + f) << (ip + 8);
  endfunction

  function automatic int err_ref(int lg[10], int lab, int c);
    longint s = 0;
    longint p;
    int d, sc;
    for (int k = 0; k < 10; k++) s += exp_ref(lg[k]);
    p  = (exp_ref(lg[c]) * 128) / s;
    d  = int'(p) - ((c == lab) ? 128 : 0);
    sc = d + (d >>> 2) + (d >>> 3);
    if (sc > 127) sc = 127;
    if (sc < -128) sc = -128;
    return sc;
  endfunction

  function automatic logic [79:0] pack(int lg[10]);
    logic [79:0] v;
    for (int k = 0; k < 10; k++) v[k*8 +: 8] = 8'(lg[k]);
    return v;
  endfunction

  task automatic run_sample(string tag, int lg[10], int lab, bit inject);
    int lat;
    int other[10];
    @(negedge clk);
    logits_i = pack(lg); label_i = 4'(lab); start_i = 1;
    @(posedge clk); lat = 1;
    @(negedge clk); start_i = 0;
    if (inject) begin
      for (int k = 0; k < 10; k++) other[k] = 100 - 20 * k;
      for (int k = 0; k < 3; k++) begin @(posedge clk); lat++; @(negedge clk); end
      logits_i = pack(other); label_i = 4'((lab + 1) % 10); start_i = 1;
      @(posedge clk); lat++;
      @(negedge clk); start_i = 0;
    end
    while (!err_valid_o && lat < 40) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    check({tag, " R7 latency"}, lat, 12);
    for (int c = 0; c < 10; c++) begin
      check({tag, " R7 class order"}, int'(err_cls_o), c);
      check({tag, " R7 valid"}, int'(err_valid_o), 1);
      check({tag, " R4 R5 R6 error"}, int'($signed(err_o)), err_ref(lg, lab, c));
      @(negedge clk);
    end
    check({tag, " R7 valid drops"}, int'(err_valid_o), 0);
  endtask

  task automatic expect_quiet(string req, int cycles);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (err_valid_o) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(err_valid_o), 0);
    check("R1 err in reset", int'(err_o), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", int'(err_valid_o), 0);
  endtask

  task automatic t_equal;
    int lg[10] = '{default: 0};
    run_sample("equal R2 R3", lg, 3, 0);
  endtask

  task automatic t_dominant_target;
    int lg[10] = '{default: -128};
    lg[5] = 127;
    run_sample("dominant target R3", lg, 5, 0);
  endtask

  task automatic t_dominant_wrong;
    int lg[10] = '{default: -128};
    lg[3] = 127;
    run_sample("dominant wrong R6 saturation", lg, 0, 0);
  endtask

  task automatic t_mixed;
    int lg[10] = '{10, -20, 33, 0, -5, 64, -64, 17, 1, -1};
    run_sample("mixed R2 R5", lg, 9, 0);
  endtask

  task automatic t_close;
    int lg[10] = '{16, 17, 18, 19, 20, 21, 22, 23, 24, 25};
    run_sample("close R5 small errors", lg, 2, 0);
  endtask

  task automatic t_reject;
    foreach (label_i[i]) ;
    @(negedge clk);
    logits_i = '0; label_i = 4'd10; start_i = 1;
    @(negedge clk);
    label_i = 4'd15;
    @(negedge clk); start_i = 0;
    expect_quiet("R8 rejected label produces nothing", 30);
  endtask

  task automatic t_busy;
    int lg[10] = '{10, -20, 33, 0, -5, 64, -64, 17, 1, -1};
    run_sample("busy start R9", lg, 9, 1);
    expect_quiet("R9 no extra results", 30);
  endtask

  initial begin
    t_reset();
    t_equal();
    t_dominant_target();
    t_mixed();
    t_equal();
    t_dominant_wrong();
    t_close();
    t_reject();
    t_mixed();
    t_busy();
    run_sample("after reject R10", '{-128, -100, -50, 0, 50, 100, 127, -1, 2, 3}, 6, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule